// File: doc/BRIEF.md
# Complex Mixer With Selectable Sideband

This block takes a stream of real signed samples and multiplies each one by a complex local oscillator. The oscillator is a 32-bit phase accumulator followed by a quarter-wave sine table. The two products, in-phase and quadrature, are rounded and saturated and then go to the decimation filters that follow. Those filters are outside this block.

Each sample carries two mode inputs. The first is `spec_rev`. When it is low, the quadrature multiplier is the negated sine, so the oscillator vector turns clockwise and the upper sideband moves down to baseband. When it is high, the sine goes through without negation, so the vector turns the other way and the lower sideband lands at baseband instead. Nothing else differs between the two modes.

The second is `filt_only`. It replaces the oscillator with fixed multipliers: full scale on I and zero on Q. The input then passes to I unchanged, apart from saturation, for use with the filters alone. This mode is meant to run with the phase increment and phase offset both programmed to zero.

Top module: `cmix_top`

## Requirements
- R1: A synchronous reset clears the phase accumulator to zero and clears `out_valid`, `out_i` and `out_q`. The first valid sample after reset uses the phase `phase_ofs`.
- R2: Each cycle with `in_valid` high adds `phase_inc` to the accumulator, modulo 2^32. A cycle with `in_valid` low leaves the accumulator unchanged, so the phase advances only with valid samples.
- R3: A sample uses the accumulator value from before its own increment. The accumulator plus `phase_ofs`, modulo 2^32, is formed, and its upper 10 bits form the table address k.
- R4: The oscillator words are 19-bit signed: C = round(262143·cos(2π(k+0.5)/1024)) and S = round(262143·sin(2π(k+0.5)/1024)). In the normal mode (`spec_rev`=0), I = scale(x·C) and Q = scale(−x·S).
- R5: When `spec_rev`=1, Q = scale(x·S). I is identical to the normal mode for the same phase, and Q is the exact negation of the normal-mode Q.
- R6: When `filt_only`=1, the I multiplier is 0x3FFFF and the Q multiplier is 0. So `out_q` = 0, and `out_i` equals the input sample, except for the saturated case in R7.
- R7: scale(p) divides by 2^18 and rounds halves away from zero. It then saturates symmetrically to ±131071, so an output never takes the value −131072. For example, an input of −131072 in filter-only mode gives −131071.
- R8: `out_valid` follows `in_valid` with a fixed latency of exactly 3 clock cycles, and the result appears in that same cycle.
- R9: `out_i` and `out_q` hold their previous values in every cycle in which `out_valid` is low.
- R10: `spec_rev` and `filt_only` are captured together with each sample, so the mode may change on every sample without affecting samples that are already in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe; also advances the phase |
| in_sample | input | 18 | Real input sample, two's complement |
| phase_inc | input | 32 | Phase increment added per valid sample |
| phase_ofs | input | 32 | Phase offset added after the accumulator |
| spec_rev | input | 1 | 1 selects lower-sideband (up) conversion |
| filt_only | input | 1 | 1 replaces the oscillator with fixed multipliers |
| out_valid | output | 1 | Result strobe, 3 cycles after `in_valid` |
| out_i | output | 18 | In-phase product, rounded and saturated |
| out_q | output | 18 | Quadrature product, rounded and saturated |

## Verification
The bench builds the block with its default parameters: 18-bit samples and outputs, 19-bit oscillator words, a 32-bit phase and a 10-bit table address. With these values every quadrant of the 1024-point table can be reached in a few dozen samples, accumulator wrap-around can be reached with one large increment, and the lone saturating input (−131072 at full-scale gain) can be driven directly. The bench runs mixing with several increments and offsets and with valid gaps. It also switches the mode on every sample, replays one sample stream in both sideband modes to demand exact negation of Q, and drives the extreme samples in filter-only mode.

// File: rtl/cmix_pkg.sv
package cmix_pkg;

  // Fixed-point scale used while building the sine table (2^30 = 1.0)
  localparam int     FX_FRAC    = 30;
  localparam longint FX_HALF    = longint'(1) <<< (FX_FRAC - 1);
  localparam longint HALF_PI_FX = 64'sd1686629713;

  // Oscillator selection carried alongside each sample
  typedef enum logic [1:0] {
    LO_DOWN  = 2'd0,
    LO_UP    = 2'd1,
    LO_FIXED = 2'd2
  } lo_mode_e;

  // Quarter-wave sine entry j of qn entries, at angle (j+0.5)*(pi/2)/qn,
  // scaled by amp and rounded. Evaluated with an odd Taylor series in
  // 2^30 fixed point; only used for elaboration-time constants.
  function automatic longint qsin(int j, int qn, longint amp);
    longint th;
    longint x2;
    longint term;
    longint acc;
    th   = (HALF_PI_FX * longint'(2 * j + 1)) / longint'(2 * qn);
    x2   = (th * th) >>> FX_FRAC;
    term = th;
    acc  = th;
    for (int n = 1; n <= 6; n++) begin
      term = -(((term * x2) >>> FX_FRAC) / longint'((2 * n) * (2 * n + 1)));
      acc  = acc + term;
    end
    return (acc * amp + FX_HALF) >>> FX_FRAC;
  endfunction

  // Drop sh fraction bits rounding halves away from zero, then clip
  // symmetrically to +/- lim.
  function automatic longint round_sat(longint p, int sh, longint lim);
    longint mag;
    longint r;
    mag = (p < 0) ? -p : p;
    r   = (mag + (longint'(1) <<< (sh - 1))) >>> sh;
    if (r > lim) r = lim;
    return (p < 0) ? -r : r;
  endfunction

endpackage

// File: rtl/cmix_phase.sv
module cmix_phase #(
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [PHASE_W-1:0] phase_inc,
  input  logic [PHASE_W-1:0] phase_ofs,
  output logic [ADDR_W-1:0]  lo_addr
);

  localparam int ADDR_LSB = PHASE_W - ADDR_W;

  logic [PHASE_W-1:0] acc_q;
  logic [PHASE_W-1:0] phase_sum;

  // Named events for the checks below
  wire step_evt = in_valid;

  assign phase_sum = acc_q + phase_ofs;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      lo_addr <= '0;
    end else begin
      lo_addr <= phase_sum[PHASE_W-1:ADDR_LSB];
      if (step_evt) acc_q <= acc_q + phase_inc;
    end
  end

  // R1: reset leaves a cleared accumulator behind it
  a_r1_acc_cleared: assert property (@(posedge clk) rst |=> (acc_q == '0));

  // R2: no valid sample, no phase movement
  a_r2_phase_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(step_evt) && !$past(rst)) |-> $stable(acc_q));

endmodule

// File: rtl/cmix_lo.sv
module cmix_lo #(
  parameter int ADDR_W = 10,
  parameter int TRIG_W = 19
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          lo_addr,
  input  cmix_pkg::lo_mode_e         mode,
  output logic signed [TRIG_W-1:0]   lo_im,
  output logic signed [TRIG_W-1:0]   lo_qm
);
  import cmix_pkg::*;

  localparam int     QA  = ADDR_W - 2;
  localparam int     QN  = 1 << QA;
  localparam longint AMP = (longint'(1) <<< (TRIG_W - 1)) - 1;
  localparam logic signed [TRIG_W-1:0] FULL_SCALE = {1'b0, {(TRIG_W-1){1'b1}}};

  logic signed [TRIG_W-1:0] qtab [QN];

  for (genvar g = 0; g < QN; g++) begin : g_qtab
    localparam longint QV = qsin(g, QN, AMP);
    assign qtab[g] = TRIG_W'(QV);
  end

  logic [1:0]               quad;
  logic [QA-1:0]            j_fwd;
  logic [QA-1:0]            j_rev;
  logic signed [TRIG_W-1:0] t_fwd;
  logic signed [TRIG_W-1:0] t_rev;
  logic signed [TRIG_W-1:0] sin_c;
  logic signed [TRIG_W-1:0] cos_c;

  assign quad  = lo_addr[ADDR_W-1 -: 2];
  assign j_fwd = lo_addr[QA-1:0];
  assign j_rev = ~lo_addr[QA-1:0];
  assign t_fwd = qtab[j_fwd];
  assign t_rev = qtab[j_rev];

  // Fold the quarter wave into the full circle
  always_comb begin
    unique case (quad)
      2'd0: begin sin_c =  t_fwd; cos_c =  t_rev; end
      2'd1: begin sin_c =  t_rev; cos_c = -t_fwd; end
      2'd2: begin sin_c = -t_fwd; cos_c = -t_rev; end
      default: begin sin_c = -t_rev; cos_c =  t_fwd; end
    endcase
  end

  wire fixed_sel = (mode == LO_FIXED);
  wire up_sel    = (mode == LO_UP);

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_im <= '0;
      lo_qm <= '0;
    end else if (fixed_sel) begin
      lo_im <= FULL_SCALE;
      lo_qm <= '0;
    end else if (up_sel) begin
      lo_im <= cos_c;
      lo_qm <= sin_c;
    end else begin
      lo_im <= cos_c;
      lo_qm <= -sin_c;
    end
  end

  // R6: fixed mode presents full scale on I and nothing on Q
  a_r6_fixed_mult: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == LO_FIXED) |-> (lo_im == FULL_SCALE && lo_qm == '0));

  // R4: in the first quadrant the down-converting vector sits below the axis
  a_r4_quadrant_sign: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == LO_DOWN && $past(lo_addr[ADDR_W-1 -: 2]) == 2'd0)
      |-> (lo_im > 0 && lo_qm < 0));

  // R5: the up-converting vector in the first quadrant sits above the axis
  a_r5_quadrant_sign: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == LO_UP && $past(lo_addr[ADDR_W-1 -: 2]) == 2'd0)
      |-> (lo_im > 0 && lo_qm > 0));

endmodule

// File: rtl/cmix_mul.sv
module cmix_mul #(
  parameter int SAMPLE_W = 18,
  parameter int TRIG_W   = 19,
  parameter int OUT_W    = 18
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       en,
  input  logic signed [SAMPLE_W-1:0] x,
  input  logic signed [TRIG_W-1:0]   lo_im,
  input  logic signed [TRIG_W-1:0]   lo_qm,
  output logic signed [OUT_W-1:0]    out_i,
  output logic signed [OUT_W-1:0]    out_q
);
  import cmix_pkg::*;

  localparam int     SH  = TRIG_W - 1;
  localparam longint LIM = (longint'(1) <<< (OUT_W - 1)) - 1;
  localparam logic signed [OUT_W-1:0] NEG_EDGE = {1'b1, {(OUT_W-1){1'b0}}};

  logic signed [OUT_W-1:0] pi_c;
  logic signed [OUT_W-1:0] pq_c;

  always_comb begin
    pi_c = OUT_W'(round_sat(longint'(x) * longint'(lo_im), SH, LIM));
    pq_c = OUT_W'(round_sat(longint'(x) * longint'(lo_qm), SH, LIM));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_i <= '0;
      out_q <= '0;
    end else if (en) begin
      out_i <= pi_c;
      out_q <= pq_c;
    end
  end

  // R7: symmetric clipping never yields the most negative code
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (out_i != NEG_EDGE) && (out_q != NEG_EDGE));

  // R9: results stay put between strobes
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(en)) |-> ($stable(out_i) && $stable(out_q)));

endmodule

// File: rtl/cmix_top.sv
module cmix_top #(
  parameter int SAMPLE_W = 18,
  parameter int TRIG_W   = 19,
  parameter int OUT_W    = 18,
  parameter int PHASE_W  = 32,
  parameter int ADDR_W   = 10
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] in_sample,
  input  logic [PHASE_W-1:0]         phase_inc,
  input  logic [PHASE_W-1:0]         phase_ofs,
  input  logic                       spec_rev,
  input  logic                       filt_only,
  output logic                       out_valid,
  output logic signed [OUT_W-1:0]    out_i,
  output logic signed [OUT_W-1:0]    out_q
);
  import cmix_pkg::*;

  localparam int LAT = 3;

  // Stage 1: sample, mode and address
  logic signed [SAMPLE_W-1:0] x_s1;
  lo_mode_e                   mode_s1;
  logic                       v_s1;
  logic [ADDR_W-1:0]          addr_s1;
  // Stage 2: oscillator words
  logic signed [SAMPLE_W-1:0] x_s2;
  logic                       v_s2;
  logic signed [TRIG_W-1:0]   im_s2;
  logic signed [TRIG_W-1:0]   qm_s2;

  lo_mode_e mode_in;
  always_comb begin
    if (filt_only)     mode_in = LO_FIXED;
    else if (spec_rev) mode_in = LO_UP;
    else               mode_in = LO_DOWN;
  end

  cmix_phase #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W)) u_phase (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .phase_inc (phase_inc),
    .phase_ofs (phase_ofs),
    .lo_addr   (addr_s1)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      x_s1      <= '0;
      mode_s1   <= LO_DOWN;
      v_s1      <= 1'b0;
      x_s2      <= '0;
      v_s2      <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      x_s1      <= in_sample;
      mode_s1   <= mode_in;
      v_s1      <= in_valid;
      x_s2      <= x_s1;
      v_s2      <= v_s1;
      out_valid <= v_s2;
    end
  end

  cmix_lo #(.ADDR_W(ADDR_W), .TRIG_W(TRIG_W)) u_lo (
    .clk     (clk),
    .rst     (rst),
    .lo_addr (addr_s1),
    .mode    (mode_s1),
    .lo_im   (im_s2),
    .lo_qm   (qm_s2)
  );

  cmix_mul #(.SAMPLE_W(SAMPLE_W), .TRIG_W(TRIG_W), .OUT_W(OUT_W)) u_mul (
    .clk   (clk),
    .rst   (rst),
    .en    (v_s2),
    .x     (x_s2),
    .lo_im (im_s2),
    .lo_qm (qm_s2),
    .out_i (out_i),
    .out_q (out_q)
  );

  // Edges seen since reset, saturating at the pipeline depth
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                    since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end
  wire pipe_primed = (since_rst == 2'(LAT));

  // R8: strobe emerges exactly three cycles after it entered
  a_r8_latency: assert property (@(posedge clk) disable iff (rst)
    pipe_primed |-> (out_valid == $past(in_valid, 3)));

  // R8: nothing emerges before the pipeline has filled after reset
  a_r8_no_early: assert property (@(posedge clk) disable iff (rst)
    !pipe_primed |-> !out_valid);

  // R6: a filter-only sample leaves Q at zero at the output
  a_r6_q_zero: assert property (@(posedge clk) disable iff (rst)
    (pipe_primed && out_valid && $past(filt_only, 3)) |-> (out_q == '0));

  // R1: reset empties the output strobe and data
  a_r1_out_cleared: assert property (@(posedge clk)
    rst |=> (!out_valid && out_i == '0 && out_q == '0));

endmodule

// File: tb/cmix_top_tb.sv
module cmix_top_tb;
  localparam int     CLK_PERIOD = 10;
  localparam longint GAIN       = 262143;
  localparam longint CLIP       = 131071;
  localparam real    TWO_PI     = 6.283185307179586;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               in_valid = 1'b0;
  logic signed [17:0] in_sample = '0;
  logic [31:0]        phase_inc = '0;
  logic [31:0]        phase_ofs = '0;
  logic               spec_rev = 1'b0;
  logic               filt_only = 1'b0;
  logic               out_valid;
  logic signed [17:0] out_i;
  logic signed [17:0] out_q;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmix_top u_dut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .phase_inc (phase_inc),
    .phase_ofs (phase_ofs),
    .spec_rev  (spec_rev),
    .filt_only (filt_only),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q)
  );

  // ---------------- reference model ----------------
  typedef struct { bit v; longint i; longint q; bit exact; } res_t;
  res_t   dly [3];
  longint m_phase = 0;
  bit     e_v = 0;
  longint e_i = 0, e_q = 0;
  bit     e_exact = 1;

  function automatic longint osc(longint k, bit want_sin);
    real a;
    real v;
    a = TWO_PI * (real'(k) + 0.5) / 1024.0;
    v = real'(GAIN) * (want_sin ? $sin(a) : $cos(a));
    if (v >= 0.0) return longint'($floor(v + 0.5));
    return -longint'($floor(-v + 0.5));
  endfunction

  function automatic longint scale(longint p);
    longint m;
    longint r;
    m = (p < 0) ? -p : p;
    r = (m + 131072) / 262144;
    if (r > CLIP) r = CLIP;
    return (p < 0) ? -r : r;
  endfunction

  task automatic model_edge();
    res_t   n;
    longint k;
    longint x;
    x = longint'(in_sample);
    k = ((m_phase + longint'(phase_ofs)) % 64'sd4294967296) / 64'sd4194304;
    n.v = in_valid;
    if (filt_only) begin
      n.i = scale(x * GAIN);
      n.q = 0;
      n.exact = 1;
    end else begin
      n.i = scale(x * osc(k, 0));
      n.q = spec_rev ? scale(x * osc(k, 1)) : scale(-x * osc(k, 1));
      n.exact = 0;
    end
    if (rst) begin
      m_phase = 0;
      for (int s = 0; s < 3; s++) dly[s] = '{0, 0, 0, 1};
      e_v = 0; e_i = 0; e_q = 0; e_exact = 1;
    end else begin
      if (in_valid) m_phase = (m_phase + longint'(phase_inc)) % 64'sd4294967296;
      dly[2] = dly[1];
      dly[1] = dly[0];
      dly[0] = n;
      e_v = dly[2].v;
      if (dly[2].v) begin
        e_i = dly[2].i; e_q = dly[2].q; e_exact = dly[2].exact;
      end
    end
  endtask

  // ---------------- capture for the sideband replay ----------------
  int     cap_pass = 0;
  int     cap_n = 0;
  longint cap_i [2][16];
  longint cap_q [2][16];

  function automatic bit near(longint a, longint b, bit exact);
    longint d;
    d = a - b;
    if (exact) return d == 0;
    return (d <= 1) && (d >= -1);
  endfunction

  task automatic check_out(string tag);
    longint ai;
    longint aq;
    ai = longint'(out_i);
    aq = longint'(out_q);
    checks++;
    if (out_valid !== e_v) begin
      fails++;
      $display("FAIL %s out_valid actual %0d expected %0d", tag, out_valid, e_v);
    end
    checks++;
    if (!near(ai, e_i, e_exact)) begin
      fails++;
      $display("FAIL %s out_i actual %0d expected %0d", tag, ai, e_i);
    end
    checks++;
    if (!near(aq, e_q, e_exact)) begin
      fails++;
      $display("FAIL %s out_q actual %0d expected %0d", tag, aq, e_q);
    end
    if (cap_pass != 0 && out_valid === 1'b1 && cap_n < 16) begin
      cap_i[cap_pass-1][cap_n] = ai;
      cap_q[cap_pass-1][cap_n] = aq;
      cap_n++;
    end
  endtask

  task automatic cycle(logic v, logic signed [17:0] x, string tag);
    in_valid  = v;
    in_sample = x;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_out(tag);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cycle(1'b1, 18'sd999, "R1");
    cycle(1'b0, 18'sd0, "R1");
    rst = 1'b0;
  endtask

  task automatic flush(string tag);
    for (int f = 0; f < 4; f++) cycle(1'b0, 18'sd0, tag);
  endtask

  function automatic logic signed [17:0] pat(int n, int mul);
    return 18'((n * mul) % 262144 - 131072);
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    do_reset();
    cycle(1'b0, 18'sd0, "R1 reset state");

    // R2 R3 R4 R8 R9: down conversion with gaps in the strobe
    phase_inc = 32'h0100_0000; phase_ofs = 32'h0; spec_rev = 0; filt_only = 0;
    for (int n = 0; n < 24; n++) cycle((n % 3) != 2, pat(n, 9973), "R2 R3 R4 R8 R9");
    flush("R8 R9");

    // R3 R5: offset moves the start phase, lower sideband selected
    phase_inc = 32'h0350_0000; phase_ofs = 32'h4000_0000; spec_rev = 1;
    for (int n = 0; n < 20; n++) cycle(1'b1, pat(n + 3, 40503), "R3 R5");
    flush("R5 R8");

    // R2: large increment wraps the accumulator repeatedly
    phase_inc = 32'hF123_4567; phase_ofs = 32'h0; spec_rev = 0;
    for (int n = 0; n < 16; n++) cycle(1'b1, pat(n + 7, 28657), "R2 wrap");
    flush("R2 R9");

    // R10: mode changes on every sample
    phase_inc = 32'h0777_0000; phase_ofs = 32'h1000_0000;
    for (int n = 0; n < 20; n++) begin
      spec_rev  = n[0];
      filt_only = (n % 5) == 0;
      cycle(1'b1, pat(n + 11, 17711), "R10");
    end
    spec_rev = 0; filt_only = 0;
    flush("R10");

    // R6 R7: filter-only path with extreme and small samples
    do_reset();
    phase_inc = 32'h0; phase_ofs = 32'h0; filt_only = 1;
    cycle(1'b1,  18'sd0,       "R6 zero");
    cycle(1'b1,  18'sd1,       "R6 one");
    cycle(1'b1, -18'sd1,       "R6 minus one");
    cycle(1'b1,  18'sd131071,  "R6 R7 top");
    cycle(1'b1, -18'sd131072,  "R7 clip");
    cycle(1'b1, -18'sd131071,  "R6 R7 bottom");
    cycle(1'b1,  18'sd12345,   "R6");
    cycle(1'b1, -18'sd54321,   "R6");
    flush("R6 R9");
    filt_only = 0;

    // R5: identical stream in both sidebands, Q must mirror exactly
    for (int pass = 1; pass <= 2; pass++) begin
      do_reset();
      phase_inc = 32'h0777_0000; phase_ofs = 32'h1234_5678;
      spec_rev = (pass == 2);
      cap_pass = pass; cap_n = 0;
      for (int n = 0; n < 12; n++) cycle(1'b1, pat(n + 5, 37117), "R5 replay");
      flush("R5 replay");
      cap_pass = 0;
    end
    spec_rev = 0;
    for (int n = 0; n < 12; n++) begin
      checks++;
      if (cap_i[1][n] != cap_i[0][n]) begin
        fails++;
        $display("FAIL R5 I differs by mode actual %0d expected %0d", cap_i[1][n], cap_i[0][n]);
      end
      checks++;
      if (cap_q[1][n] != -cap_q[0][n]) begin
        fails++;
        $display("FAIL R5 Q not mirrored actual %0d expected %0d", cap_q[1][n], -cap_q[0][n]);
      end
    end

    // R1: reset mid-stream clears everything again
    phase_inc = 32'h0200_0000; phase_ofs = 32'h2000_0000;
    for (int n = 0; n < 4; n++) cycle(1'b1, pat(n, 3001), "R4");
    do_reset();
    cycle(1'b0, 18'sd0, "R1 after reset");
    for (int n = 0; n < 6; n++) cycle(1'b1, pat(n + 1, 3001), "R1 first phase");
    flush("R1");

    summary();
    $finish;
  end

endmodule